// File: doc/BRIEF.md
# Area-Indexed Address Translation Selector

This block picks a translation method for each 64-bit effective address by looking at the address's top four bits. Those bits select one of sixteen area descriptors that software writes. Each descriptor names a method. Areas can therefore mix methods: a process area mapped by page tables, a large contiguous kernel or frame-buffer area relocated by arithmetic, and areas paged through a single flat entry vector.

A direct-block area is resolved entirely inside the block. The area offset is checked against the area size. The requested access is checked against the area's read/write/execute permissions. When both checks pass, the physical address is the effective address plus the descriptor's 64-bit offset. The block reads no memory for this. A page-table area returns the root frame address and the starting level to an external walker, so the walk can start below the top level. An indirect-block area runs the same checks as a direct area. It then hands the relocated area offset and the base of the entry vector to the indirect engine. A process switch only rewrites the descriptor for area 0.

Top module: `area_xlat_sel`

## Requirements
- R1: After reset, rsp_valid_o is low and all sixteen descriptors hold the invalid method, so any request reports the invalid-area fault.
- R2: The descriptor used for a request is the one whose index equals req_ea_i[63:60].
- R3: The method field encodes 0 = invalid, 1 = page table, 2 = direct block, 3 = indirect block. Selecting an invalid descriptor returns fault code 1 (invalid area). It also returns handoff 0 and zero address, root, level and cache fields.
- R4: For a direct area that passes its checks, the response is fault 0 and handoff 2. It carries rsp_pa_o = req_ea_i + offset (mod 2^64) and the descriptor's cache attributes. Root and level are zero.
- R5: For direct and indirect areas, the area offset {4'b0, req_ea_i[59:0]} is compared with the size. If the offset is greater than or equal to the size, the response is fault code 2 (bounds) with handoff 0 and zero address. The bounds check takes priority over the permission check.
- R6: The permission bits are bit 0 read, bit 1 write and bit 2 execute. The access codes are 0 read, 1 write and 2 execute, and code 3 is never permitted. A request that is in range but not permitted returns fault code 3 (protection) with handoff 0 and no address.
- R7: A page-table area returns fault 0 and handoff 1. It carries the descriptor's root frame address on rsp_root_o and its starting level on rsp_level_o, with rsp_pa_o zero. No bounds or permission check applies. The level output is zero for every other handoff.
- R8: An indirect area that passes its checks returns fault 0 and handoff 3. It carries rsp_pa_o = req_ea_i + offset, and the entry-vector base (the descriptor root field) on rsp_root_o.
- R9: The response is registered. rsp_valid_o equals req_valid_i from the previous cycle, and the fields belong to that request.
- R10: Writing one descriptor leaves the other fifteen unchanged.
- R11: A request in the same cycle as a write to its own area uses the descriptor contents from before the write. The write applies from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Descriptor write strobe |
| wr_area_i | input | 4 | Descriptor index to write |
| wr_method_i | input | 2 | Method code to store |
| wr_perm_i | input | 3 | Permission bits {exec, write, read} |
| wr_cache_i | input | 4 | Cache-control attributes |
| wr_level_i | input | 3 | Starting walk level (page-table areas) |
| wr_size_i | input | 64 | Area size in bytes |
| wr_offset_i | input | 64 | Relocation offset added to the address |
| wr_root_i | input | 64 | Root frame or entry-vector base address |
| req_valid_i | input | 1 | Translate request valid |
| req_ea_i | input | 64 | Effective address |
| req_acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_pa_o | output | 64 | Physical address or relocated area offset |
| rsp_cache_o | output | 4 | Cache attributes of the selected area |
| rsp_fault_o | output | 2 | 0 none, 1 invalid area, 2 bounds, 3 protection |
| rsp_handoff_o | output | 2 | Method that takes over; 0 on a fault |
| rsp_root_o | output | 64 | Root frame or entry-vector base |
| rsp_level_o | output | 3 | Starting level for the walker |

## Verification
Random descriptors of all four methods are mixed with random addresses. The addresses fall on both sides of each area's size, so the bounds decision is exercised at many distances from the limit. Random access types, with all permission masks, separate the protection fault from the bounds fault. Directed cases cover these points:
- the last in-range byte against the first out-of-range byte;
- an offset that wraps past 2^64;
- the reserved access code;
- out-of-range accesses that are also forbidden;
- rewriting area 0 alone;
- a write and a request to the same area in the same cycle, which shows whether the old or the new descriptor was used.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned XL_AW      = 64;
  localparam int unsigned XL_AREAS   = 16;
  localparam int unsigned XL_SEL_W   = $clog2(XL_AREAS);
  localparam int unsigned XL_PERM_W  = 3;
  localparam int unsigned XL_CACHE_W = 4;
  localparam int unsigned XL_LVL_W   = 3;

  typedef enum logic [1:0] {
    M_INVALID  = 2'd0,
    M_PAGE     = 2'd1,
    M_DIRECT   = 2'd2,
    M_INDIRECT = 2'd3
  } method_e;

  typedef enum logic [1:0] {
    F_NONE   = 2'd0,
    F_AREA   = 2'd1,
    F_BOUNDS = 2'd2,
    F_PROT   = 2'd3
  } fault_e;

  typedef struct packed {
    method_e                 method;
    logic [XL_PERM_W-1:0]    perm;
    logic [XL_CACHE_W-1:0]   cache;
    logic [XL_LVL_W-1:0]     level;
    logic [XL_AW-1:0]        size;
    logic [XL_AW-1:0]        offset;
    logic [XL_AW-1:0]        root;
  } area_desc_t;

  typedef struct packed {
    logic [XL_AW-1:0]        pa;
    logic [XL_CACHE_W-1:0]   cache;
    fault_e                  fault;
    method_e                 handoff;
    logic [XL_AW-1:0]        root;
    logic [XL_LVL_W-1:0]     level;
  } xlat_rsp_t;
endpackage

// File: rtl/area_desc_table.sv
module area_desc_table
  import xlat_pkg::*;
#(
  parameter int unsigned N_AREAS = XL_AREAS,
  localparam int unsigned IDX_W  = $clog2(N_AREAS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  area_desc_t       wr_desc_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output area_desc_t       rd_desc_o
);
  area_desc_t entry_q [N_AREAS];

  for (genvar i = 0; i < N_AREAS; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  entry_q[i] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(i))    entry_q[i] <= wr_desc_i;
    end
  end

  // combinational read: a same-cycle write is seen from the next cycle
  assign rd_desc_o = entry_q[rd_idx_i];
endmodule

// File: rtl/area_xlat_eval.sv
module area_xlat_eval
  import xlat_pkg::*;
(
  input  area_desc_t       desc_i,
  input  logic [XL_AW-1:0] ea_i,
  input  logic [1:0]       acc_i,
  output xlat_rsp_t        rsp_o
);
  logic [XL_AW-1:0] area_off;
  logic [XL_AW-1:0] reloc;
  logic             in_range;
  logic             perm_ok;

  assign area_off = {{XL_SEL_W{1'b0}}, ea_i[XL_AW-XL_SEL_W-1:0]};
  assign in_range = area_off < desc_i.size;
  assign reloc    = ea_i + desc_i.offset;

  always_comb begin
    unique case (acc_i)
      2'd0:    perm_ok = desc_i.perm[0];
      2'd1:    perm_ok = desc_i.perm[1];
      2'd2:    perm_ok = desc_i.perm[2];
      default: perm_ok = 1'b0;
    endcase
  end

  always_comb begin
    rsp_o = '0;
    unique case (desc_i.method)
      M_INVALID: rsp_o.fault = F_AREA;
      M_PAGE: begin
        rsp_o.handoff = M_PAGE;
        rsp_o.cache   = desc_i.cache;
        rsp_o.root    = desc_i.root;
        rsp_o.level   = desc_i.level;
      end
      default: begin // direct or indirect block
        if (!in_range)      rsp_o.fault = F_BOUNDS;
        else if (!perm_ok)  rsp_o.fault = F_PROT;
        else begin
          rsp_o.handoff = desc_i.method;
          rsp_o.cache   = desc_i.cache;
          rsp_o.pa      = reloc;
          if (desc_i.method == M_INDIRECT) rsp_o.root = desc_i.root;
        end
      end
    endcase
  end
endmodule

// File: rtl/area_xlat_sel.sv
module area_xlat_sel
  import xlat_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [XL_SEL_W-1:0]   wr_area_i,
  input  logic [1:0]            wr_method_i,
  input  logic [XL_PERM_W-1:0]  wr_perm_i,
  input  logic [XL_CACHE_W-1:0] wr_cache_i,
  input  logic [XL_LVL_W-1:0]   wr_level_i,
  input  logic [XL_AW-1:0]      wr_size_i,
  input  logic [XL_AW-1:0]      wr_offset_i,
  input  logic [XL_AW-1:0]      wr_root_i,
  input  logic                  req_valid_i,
  input  logic [XL_AW-1:0]      req_ea_i,
  input  logic [1:0]            req_acc_i,
  output logic                  rsp_valid_o,
  output logic [XL_AW-1:0]      rsp_pa_o,
  output logic [XL_CACHE_W-1:0] rsp_cache_o,
  output logic [1:0]            rsp_fault_o,
  output logic [1:0]            rsp_handoff_o,
  output logic [XL_AW-1:0]      rsp_root_o,
  output logic [XL_LVL_W-1:0]   rsp_level_o
);
  area_desc_t wr_desc;
  area_desc_t sel_desc;
  xlat_rsp_t  rsp_d;
  xlat_rsp_t  rsp_q;
  logic       valid_q;

  assign wr_desc = '{
    method: method_e'(wr_method_i),
    perm:   wr_perm_i,
    cache:  wr_cache_i,
    level:  wr_level_i,
    size:   wr_size_i,
    offset: wr_offset_i,
    root:   wr_root_i
  };

  area_desc_table #(.N_AREAS(XL_AREAS)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_area_i),
    .wr_desc_i (wr_desc),
    .rd_idx_i  (req_ea_i[XL_AW-1 -: XL_SEL_W]),
    .rd_desc_o (sel_desc)
  );

  area_xlat_eval u_eval (
    .desc_i (sel_desc),
    .ea_i   (req_ea_i),
    .acc_i  (req_acc_i),
    .rsp_o  (rsp_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      rsp_q   <= '0;
    end else begin
      valid_q <= req_valid_i;
      if (req_valid_i) rsp_q <= rsp_d;
    end
  end

  assign rsp_valid_o   = valid_q;
  assign rsp_pa_o      = rsp_q.pa;
  assign rsp_cache_o   = rsp_q.cache;
  assign rsp_fault_o   = rsp_q.fault;
  assign rsp_handoff_o = rsp_q.handoff;
  assign rsp_root_o    = rsp_q.root;
  assign rsp_level_o   = rsp_q.level;
endmodule

// File: rtl/area_xlat_chk.sv
module area_xlat_chk
  import xlat_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic                  rsp_valid_o,
  input logic [XL_AW-1:0]      rsp_pa_o,
  input logic [XL_CACHE_W-1:0] rsp_cache_o,
  input logic [1:0]            rsp_fault_o,
  input logic [1:0]            rsp_handoff_o,
  input logic [XL_AW-1:0]      rsp_root_o,
  input logic [XL_LVL_W-1:0]   rsp_level_o
);
  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  assert_rsp_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> rsp_valid_o == $past(req_valid_i));

  assert_bad_area_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o == 2'd1 |-> rsp_cache_o == '0 && rsp_level_o == '0);

  assert_fault_no_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o != 2'd0 |-> rsp_pa_o == '0 && rsp_handoff_o == 2'd0 && rsp_root_o == '0);

  assert_walk_no_pa_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_handoff_o == 2'd1 |-> rsp_pa_o == '0 && rsp_fault_o == 2'd0);

  assert_level_walk_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_handoff_o != 2'd1 |-> rsp_level_o == '0);

  assert_direct_no_root_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_handoff_o == 2'd2 |-> rsp_root_o == '0 && rsp_fault_o == 2'd0);
endmodule

bind area_xlat_sel area_xlat_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_pa_o      (rsp_pa_o),
  .rsp_cache_o   (rsp_cache_o),
  .rsp_fault_o   (rsp_fault_o),
  .rsp_handoff_o (rsp_handoff_o),
  .rsp_root_o    (rsp_root_o),
  .rsp_level_o   (rsp_level_o)
);

// File: tb/area_xlat_sel_tb.sv
`timescale 1ns/1ps
module area_xlat_sel_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_area_i = '0;
  logic [1:0]  wr_method_i = '0;
  logic [2:0]  wr_perm_i = '0;
  logic [3:0]  wr_cache_i = '0;
  logic [2:0]  wr_level_i = '0;
  logic [63:0] wr_size_i = '0, wr_offset_i = '0, wr_root_i = '0;
  logic        req_valid_i = 1'b0;
  logic [63:0] req_ea_i = '0;
  logic [1:0]  req_acc_i = '0;
  logic        rsp_valid_o;
  logic [63:0] rsp_pa_o, rsp_root_o;
  logic [3:0]  rsp_cache_o;
  logic [1:0]  rsp_fault_o, rsp_handoff_o;
  logic [2:0]  rsp_level_o;

  always #4 clk_i = ~clk_i;

  area_xlat_sel u_dut (.*);

  int n_chk = 0, n_fail = 0;

  // bench model of the descriptor table
  logic [1:0]  m_meth [16];
  logic [2:0]  m_perm [16];
  logic [3:0]  m_cache[16];
  logic [2:0]  m_lvl  [16];
  logic [63:0] m_size [16], m_off[16], m_root[16];

  logic [63:0] e_pa, e_root;
  logic [3:0]  e_cache;
  logic [1:0]  e_fault, e_hand;
  logic [2:0]  e_lvl;

  task automatic expect_of(input logic [63:0] ea, input logic [1:0] acc);
    int a = int'(ea[63:60]);
    logic [63:0] off = {4'h0, ea[59:0]};
    logic pok = (acc == 2'd3) ? 1'b0 : m_perm[a][acc];
    e_pa = '0; e_root = '0; e_cache = '0; e_fault = 2'd0; e_hand = 2'd0; e_lvl = '0;
    if (m_meth[a] == 2'd0) e_fault = 2'd1;
    else if (m_meth[a] == 2'd1) begin
      e_hand = 2'd1; e_cache = m_cache[a]; e_root = m_root[a]; e_lvl = m_lvl[a];
    end else if (off >= m_size[a]) e_fault = 2'd2;
    else if (!pok) e_fault = 2'd3;
    else begin
      e_hand = m_meth[a]; e_cache = m_cache[a]; e_pa = ea + m_off[a];
      if (m_meth[a] == 2'd3) e_root = m_root[a];
    end
  endtask

  task automatic check_rsp(input string tag);
    n_chk++;
    if (rsp_valid_o !== 1'b1 || rsp_pa_o !== e_pa || rsp_root_o !== e_root ||
        rsp_cache_o !== e_cache || rsp_fault_o !== e_fault ||
        rsp_hand_ok() == 1'b0 || rsp_level_o !== e_lvl) begin
      n_fail++;
      $display("FAIL %s: got v=%b pa=%h root=%h c=%h f=%0d h=%0d l=%0d exp v=1 pa=%h root=%h c=%h f=%0d h=%0d l=%0d",
               tag, rsp_valid_o, rsp_pa_o, rsp_root_o, rsp_cache_o, rsp_fault_o, rsp_handoff_o,
               rsp_level_o, e_pa, e_root, e_cache, e_fault, e_hand, e_lvl);
    end
  endtask

  function automatic logic rsp_hand_ok();
    return rsp_handoff_o === e_hand;
  endfunction

  // one cycle: optional write and/or request; called just after a negedge
  task automatic cycle(input logic do_wr, input logic do_req, input logic [63:0] ea,
                       input logic [1:0] acc, input string tag);
    int a;
    wr_en_i = do_wr; req_valid_i = do_req; req_ea_i = ea; req_acc_i = acc;
    if (do_req) expect_of(ea, acc);
    @(posedge clk_i);
    if (do_wr) begin
      a = int'(wr_area_i);
      m_meth[a] = wr_method_i; m_perm[a] = wr_perm_i; m_cache[a] = wr_cache_i;
      m_lvl[a] = wr_level_i; m_size[a] = wr_size_i; m_off[a] = wr_offset_i; m_root[a] = wr_root_i;
    end
    @(negedge clk_i);
    wr_en_i = 1'b0; req_valid_i = 1'b0;
    if (do_req) check_rsp(tag);
    else begin
      n_chk++;
      if (rsp_valid_o !== 1'b0) begin
        n_fail++;
        $display("FAIL %s: rsp_valid_o got %b exp 0", tag, rsp_valid_o);
      end
    end
  endtask

  task automatic set_wr(input logic [3:0] a, input logic [1:0] m, input logic [2:0] p,
                        input logic [3:0] c, input logic [2:0] l, input logic [63:0] s,
                        input logic [63:0] o, input logic [63:0] r);
    wr_area_i = a; wr_method_i = m; wr_perm_i = p; wr_cache_i = c;
    wr_level_i = l; wr_size_i = s; wr_offset_i = o; wr_root_i = r;
  endtask

  function automatic logic [63:0] r64();
    return {$urandom(), $urandom()};
  endfunction

  function automatic logic [63:0] rand_ea(input logic [3:0] a);
    logic [63:0] s = m_size[a];
    logic [59:0] lo;
    if ($urandom_range(0, 7) == 0) lo = r64()[59:0];
    else if (s != 0 && s < 64'h1_0000_0000 && $urandom_range(0, 3) == 0)
      lo = 60'(s) - 60'($urandom_range(0, 1)); // near the limit
    else lo = 60'($urandom_range(0, 32'h0003_0000));
    return {a, lo};
  endfunction

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 16; i++) begin
      m_meth[i] = '0; m_perm[i] = '0; m_cache[i] = '0; m_lvl[i] = '0;
      m_size[i] = '0; m_off[i] = '0; m_root[i] = '0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: reset state
    n_chk++;
    if (rsp_valid_o !== 1'b0) begin
      n_fail++; $display("FAIL R1: rsp_valid_o got %b exp 0", rsp_valid_o);
    end
    cycle(0, 1, {4'h9, 60'h123}, 2'd0, "R1 empty table area 9");
    cycle(0, 1, {4'h0, 60'h0}, 2'd1, "R1/R3 empty table area 0");

    // direct area 0: size 0x1000, read/write
    set_wr(4'h0, 2'd2, 3'b011, 4'h5, 3'd0, 64'h1000, 64'h8000_0000, 64'h0);
    cycle(1, 0, '0, 2'd0, "R9 idle after write");
    cycle(0, 1, {4'h0, 60'hFFF}, 2'd0, "R4 direct last byte");
    cycle(0, 1, {4'h0, 60'h1000}, 2'd0, "R5 direct first out of range");
    cycle(0, 1, {4'h0, 60'h800}, 2'd2, "R6 exec not permitted");
    cycle(0, 1, {4'h0, 60'h800}, 2'd3, "R6 reserved access code");
    cycle(0, 1, {4'h0, 60'h2000}, 2'd2, "R5 bounds before protection");
    cycle(0, 1, {4'h0, 60'h10}, 2'd1, "R4 write permitted");
    cycle(0, 0, '0, 2'd0, "R9 no request no response");

    // direct area 2 with wrapping offset
    set_wr(4'h2, 2'd2, 3'b111, 4'hA, 3'd0, 64'hFFFF, 64'hF000_0000_0000_0000, 64'h0);
    cycle(1, 0, '0, 2'd0, "R9 idle");
    cycle(0, 1, {4'h2, 60'h42}, 2'd2, "R4 offset wrap");
    // page table area 15
    set_wr(4'hF, 2'd1, 3'b000, 4'h3, 3'd2, 64'h0, 64'h0, 64'h0000_00AB_C000);
    cycle(1, 0, '0, 2'd0, "R9 idle");
    cycle(0, 1, {4'hF, 60'hFFF_FFFF_FFFF_FFFF}, 2'd3, "R7 page-table handoff");
    // indirect area 1
    set_wr(4'h1, 2'd3, 3'b001, 4'h7, 3'd5, 64'h10_0000, 64'hFFFF_FFFF_F000_0000, 64'h4000_0000);
    cycle(1, 0, '0, 2'd0, "R9 idle");
    cycle(0, 1, {4'h1, 60'h5_4321}, 2'd0, "R8 indirect handoff");
    cycle(0, 1, {4'h1, 60'h10_0000}, 2'd0, "R5 indirect bounds");
    cycle(0, 1, {4'h1, 60'h10}, 2'd1, "R6 indirect write denied");
    // R2: same low bits, different areas
    cycle(0, 1, {4'h2, 60'h10}, 2'd0, "R2 area 2");
    cycle(0, 1, {4'h3, 60'h10}, 2'd0, "R2 area 3 invalid");

    // R10: process switch rewrites only area 0
    set_wr(4'h0, 2'd1, 3'b000, 4'h1, 3'd1, 64'h0, 64'h0, 64'h0000_0000_0077_7000);
    cycle(1, 0, '0, 2'd0, "R9 idle");
    cycle(0, 1, {4'h0, 60'h1}, 2'd0, "R10 area 0 rewritten");
    cycle(0, 1, {4'hF, 60'h1}, 2'd0, "R10 area 15 unchanged");
    cycle(0, 1, {4'h1, 60'h1}, 2'd0, "R10 area 1 unchanged");

    // R11: write and request to area 3 in the same cycle
    set_wr(4'h3, 2'd2, 3'b111, 4'h2, 3'd0, 64'h100, 64'h1000, 64'h0);
    cycle(1, 1, {4'h3, 60'h20}, 2'd0, "R11 same-cycle uses old");
    cycle(0, 1, {4'h3, 60'h20}, 2'd0, "R11 next cycle uses new");

    // random mix
    for (int i = 0; i < 16; i++) begin
      set_wr(4'(i), 2'($urandom_range(0, 3)), 3'($urandom()), 4'($urandom()), 3'($urandom()),
             ($urandom_range(0, 9) == 0) ? 64'h0 : 64'($urandom_range(1, 32'h0002_0000)),
             r64(), r64());
      cycle(1, 0, '0, 2'd0, "R9 idle during load");
    end
    for (int n = 0; n < 1500; n++) begin
      logic [3:0] a = 4'($urandom());
      logic dw = ($urandom_range(0, 9) == 0);
      if (dw)
        set_wr(4'($urandom()), 2'($urandom_range(0, 3)), 3'($urandom()), 4'($urandom()),
               3'($urandom()), 64'($urandom_range(0, 32'h0002_0000)), r64(), r64());
      if ($urandom_range(0, 5) == 0) cycle(dw, 0, '0, 2'd0, "R9 random idle");
      else cycle(dw, 1, rand_ea(a), 2'($urandom()), "R2-R8 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule